// File: doc/BRIEF.md
# Protection key access checker

This block decides whether a data access to a user page may proceed under a set of sixteen software-managed protection keys. A 32-bit rights register holds two bits per key: one blocks all data access and the other blocks only writes. Each access arrives with the paging entry that mapped its page. The block takes the key number from that entry and looks up that key's two rights bits. It combines them with the access type, the user-mode flag and an enable bit from a control-register input. It then returns allow or deny, together with a fault error code.

Software reads and writes the rights register with one command port. Each command carries an index operand, and only index 0 is legal. A legal write is visible to accesses from the next cycle. A legal read returns the register one cycle later. A command with any other index leaves the register alone and raises a one-cycle invalid-operation pulse. Access results are registered and appear one cycle after the access is sampled.

Top module: `pkey_gate`

## Requirements
- R1: After synchronous reset the rights register is all zeros and `res_valid`, `res_allow`, `res_err`, `rd_valid` and `bad_op` are 0.
- R2: When bit 22 of `ctl_bits` is 0, no access is denied.
- R3: The key of an access is `acc_entry[62:59]`. For key k, rights bit 2k is access-disable and bit 2k+1 is write-disable.
- R4: With key checking enabled, a user-mode read (`acc_kind` 0) or write (`acc_kind` 1) whose key has access-disable set is denied.
- R5: With key checking enabled, write-disable set and access-disable clear, a user-mode write is denied and a user-mode read is allowed.
- R6: An instruction fetch (`acc_kind` 2 or 3) is never denied.
- R7: An access with `acc_user` 0 is never denied.
- R8: On a denied access, `res_err` has bit 5 (key violation) and bit 0 set, bit 1 equal to 1 for a write, and bit 2 equal to `acc_user`. On an allowed access `res_err` is 0.
- R9: A write command (`cmd_write` 1) with index 0 loads `cmd_wdata`. Accesses presented in the same cycle still see the old value, and later accesses see the new one.
- R10: A read command (`cmd_write` 0) with index 0 drives `rd_valid` high for one cycle, with `rd_data` holding the register value as it was at the command.
- R11: A command with a nonzero index leaves the register unchanged, gives no `rd_valid`, and pulses `bad_op` for exactly the following cycle.
- R12: `res_valid`, `res_allow` and `res_err` are registered: they reflect the access sampled on the previous clock edge, and `res_valid` is 0 when no access was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Rights command present |
| cmd_write | input | 1 | 1 = write rights, 0 = read rights |
| cmd_index | input | 32 | Index operand; only 0 is legal |
| cmd_wdata | input | 32 | New rights value for a write |
| rd_valid | output | 1 | Read result present |
| rd_data | output | 32 | Rights value returned by a read |
| bad_op | output | 1 | Pulse for a command with nonzero index |
| acc_valid | input | 1 | Access present |
| acc_entry | input | 64 | Paging entry that mapped the page |
| acc_kind | input | 2 | 0 read, 1 write, 2 or 3 fetch |
| acc_user | input | 1 | Access targets a user-mode address |
| ctl_bits | input | 32 | Control-register value; bit 22 enables key checks |
| res_valid | output | 1 | Result present |
| res_allow | output | 1 | Access allowed |
| res_err | output | 16 | Fault error code |

## Verification
Accesses are drawn at random over all sixteen keys, all four kind codes, both privilege levels and both states of the enable bit, against random rights words. These runs show whether the key is taken from the right entry bits and whether access-disable and write-disable are applied to the right access types. Directed cases isolate each override on its own: enable off, fetch and supervisor access against an all-ones rights word, and a write-disable-only key. One case presents a write command and an access in the same cycle, which shows whether the new rights take effect one cycle late. Commands with nonzero index are followed by reads, which show that the register was not disturbed.

// File: rtl/pkey_pkg.sv
package pkey_pkg;
  localparam int ERR_W      = 16;
  localparam int ERR_PRESENT = 0;
  localparam int ERR_WRITE   = 1;
  localparam int ERR_USER    = 2;
  localparam int ERR_PKEY    = 5;

  typedef enum logic [1:0] {
    KIND_READ   = 2'd0,
    KIND_WRITE  = 2'd1,
    KIND_FETCH  = 2'd2,
    KIND_FETCH2 = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic             allow;
    logic [ERR_W-1:0] err;
  } verdict_t;
endpackage

// File: rtl/pkey_rights_reg.sv
module pkey_rights_reg #(
  parameter int IDX_W    = 32,
  parameter int RIGHTS_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_valid,
  input  logic                cmd_write,
  input  logic [IDX_W-1:0]    cmd_index,
  input  logic [RIGHTS_W-1:0] cmd_wdata,
  output logic [RIGHTS_W-1:0] rights,
  output logic                rd_valid,
  output logic [RIGHTS_W-1:0] rd_data,
  output logic                bad_op
);
  logic                index_ok;
  logic [RIGHTS_W-1:0] rights_q;

  assign index_ok = (cmd_index == '0);
  assign rights   = rights_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rights_q <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      bad_op   <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      bad_op   <= 1'b0;
      if (cmd_valid) begin
        if (!index_ok) begin
          bad_op <= 1'b1;
        end else if (cmd_write) begin
          rights_q <= cmd_wdata;
        end else begin
          rd_valid <= 1'b1;
          rd_data  <= rights_q;
        end
      end
    end
  end
endmodule

// File: rtl/pkey_decide.sv
module pkey_decide #(
  parameter int NKEYS = 16,
  localparam int KEY_W    = $clog2(NKEYS),
  localparam int RIGHTS_W = 2 * NKEYS
) (
  input  logic [RIGHTS_W-1:0] rights,
  input  logic [KEY_W-1:0]    key,
  input  logic [1:0]          kind,
  input  logic                user,
  input  logic                enable,
  output pkey_pkg::verdict_t  verdict
);
  import pkey_pkg::*;

  logic [NKEYS-1:0] no_access;
  logic [NKEYS-1:0] no_write;

  for (genvar k = 0; k < NKEYS; k++) begin : g_split
    assign no_access[k] = rights[2*k];
    assign no_write[k]  = rights[2*k+1];
  end

  logic is_fetch, is_write, sel_ad, sel_wd, deny;

  always_comb begin
    is_fetch = kind[1];
    is_write = (kind == KIND_WRITE);
    sel_ad   = no_access[key];
    sel_wd   = no_write[key];
    deny     = enable && user && !is_fetch && (sel_ad || (is_write && sel_wd));

    verdict.allow = !deny;
    verdict.err   = '0;
    if (deny) begin
      verdict.err[ERR_PRESENT] = 1'b1;
      verdict.err[ERR_WRITE]   = is_write;
      verdict.err[ERR_USER]    = user;
      verdict.err[ERR_PKEY]    = 1'b1;
    end
  end
endmodule

// File: rtl/pkey_gate.sv
module pkey_gate #(
  parameter int ENTRY_W = 64,
  parameter int CR_W    = 32,
  parameter int IDX_W   = 32,
  parameter int NKEYS   = 16,
  parameter int KEY_LSB = 59,
  parameter int EN_BIT  = 22,
  localparam int KEY_W    = $clog2(NKEYS),
  localparam int RIGHTS_W = 2 * NKEYS
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cmd_valid,
  input  logic                       cmd_write,
  input  logic [IDX_W-1:0]           cmd_index,
  input  logic [RIGHTS_W-1:0]        cmd_wdata,
  output logic                       rd_valid,
  output logic [RIGHTS_W-1:0]        rd_data,
  output logic                       bad_op,
  input  logic                       acc_valid,
  input  logic [ENTRY_W-1:0]         acc_entry,
  input  logic [1:0]                 acc_kind,
  input  logic                       acc_user,
  input  logic [CR_W-1:0]            ctl_bits,
  output logic                       res_valid,
  output logic                       res_allow,
  output logic [pkey_pkg::ERR_W-1:0] res_err
);
  import pkey_pkg::*;

  logic [RIGHTS_W-1:0] rights;
  logic [KEY_W-1:0]    key;
  verdict_t            verdict;

  assign key = acc_entry[KEY_LSB +: KEY_W];

  pkey_rights_reg #(
    .IDX_W    (IDX_W),
    .RIGHTS_W (RIGHTS_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_write (cmd_write),
    .cmd_index (cmd_index),
    .cmd_wdata (cmd_wdata),
    .rights    (rights),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .bad_op    (bad_op)
  );

  pkey_decide #(
    .NKEYS (NKEYS)
  ) u_decide (
    .rights  (rights),
    .key     (key),
    .kind    (acc_kind),
    .user    (acc_user),
    .enable  (ctl_bits[EN_BIT]),
    .verdict (verdict)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_allow <= 1'b0;
      res_err   <= '0;
    end else begin
      res_valid <= acc_valid;
      res_allow <= acc_valid && verdict.allow;
      res_err   <= acc_valid ? verdict.err : '0;
    end
  end
endmodule

// File: rtl/pkey_gate_chk.sv
module pkey_gate_chk #(
  parameter int CR_W     = 32,
  parameter int IDX_W    = 32,
  parameter int RIGHTS_W = 32,
  parameter int EN_BIT   = 22
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       cmd_valid,
  input logic                       cmd_write,
  input logic [IDX_W-1:0]           cmd_index,
  input logic [RIGHTS_W-1:0]        cmd_wdata,
  input logic                       rd_valid,
  input logic [RIGHTS_W-1:0]        rd_data,
  input logic                       bad_op,
  input logic                       acc_valid,
  input logic [1:0]                 acc_kind,
  input logic                       acc_user,
  input logic [CR_W-1:0]            ctl_bits,
  input logic                       res_valid,
  input logic                       res_allow,
  input logic [pkey_pkg::ERR_W-1:0] res_err,
  input logic [RIGHTS_W-1:0]        rights
);
  p_disabled_allow_r2: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !ctl_bits[EN_BIT]) |=> res_allow);

  p_fetch_allow_r6: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_kind[1]) |=> res_allow);

  p_super_allow_r7: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_user) |=> res_allow);

  p_deny_code_r8: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_allow) |-> (res_err[5] && res_err[0]));

  p_allow_code_r8: assert property (@(posedge clk) disable iff (rst)
    res_allow |-> (res_err == '0));

  p_write_load_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_write && cmd_index == '0) |=> (rights == $past(cmd_wdata)));

  p_read_data_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_write && cmd_index == '0) |=> (rd_valid && rd_data == $past(rights)));

  p_bad_keep_r11: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_index != '0) |=> (bad_op && !rd_valid && $stable(rights)));

  p_bad_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !bad_op);

  p_result_follow_r12: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> res_valid);

  p_result_idle_r12: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> (!res_valid && !res_allow));
endmodule

bind pkey_gate pkey_gate_chk #(
  .CR_W     (CR_W),
  .IDX_W    (IDX_W),
  .RIGHTS_W (RIGHTS_W),
  .EN_BIT   (EN_BIT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_write (cmd_write),
  .cmd_index (cmd_index),
  .cmd_wdata (cmd_wdata),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .bad_op    (bad_op),
  .acc_valid (acc_valid),
  .acc_kind  (acc_kind),
  .acc_user  (acc_user),
  .ctl_bits  (ctl_bits),
  .res_valid (res_valid),
  .res_allow (res_allow),
  .res_err   (res_err),
  .rights    (rights)
);

// File: tb/pkey_gate_test.sv
module pkey_gate_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [31:0] cmd_index = '0, cmd_wdata = '0;
  logic        rd_valid, bad_op;
  logic [31:0] rd_data;
  logic        acc_valid = 1'b0;
  logic [63:0] acc_entry = '0;
  logic [1:0]  acc_kind = '0;
  logic        acc_user = 1'b0;
  logic [31:0] ctl_bits = '0;
  logic        res_valid, res_allow;
  logic [15:0] res_err;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [31:0] model = '0;

  always #2.5 clk = ~clk;

  pkey_gate uut (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_index(cmd_index),
    .cmd_wdata(cmd_wdata), .rd_valid(rd_valid), .rd_data(rd_data), .bad_op(bad_op),
    .acc_valid(acc_valid), .acc_entry(acc_entry), .acc_kind(acc_kind),
    .acc_user(acc_user), .ctl_bits(ctl_bits),
    .res_valid(res_valid), .res_allow(res_allow), .res_err(res_err)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  function automatic logic exp_deny(logic [31:0] r, logic [63:0] e, logic [1:0] k,
                                    logic u, logic [31:0] c);
    int key = int'(e[62:59]);
    if (!c[22] || !u || k[1]) return 1'b0;
    if (r[2*key]) return 1'b1;
    if (k == 2'd1 && r[2*key+1]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [15:0] exp_err(logic d, logic [1:0] k, logic u);
    logic [15:0] v = '0;
    if (d) begin
      v[0] = 1'b1; v[1] = (k == 2'd1); v[2] = u; v[5] = 1'b1;
    end
    return v;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the following negedge
  task automatic access(string req, logic [63:0] e, logic [1:0] k, logic u, logic [31:0] c);
    logic d;
    acc_valid = 1'b1; acc_entry = e; acc_kind = k; acc_user = u; ctl_bits = c;
    d = exp_deny(model, e, k, u, c);
    @(negedge clk);
    acc_valid = 1'b0;
    chk({req, " valid"}, {63'd0, res_valid}, 64'd1);
    chk({req, " allow"}, {63'd0, res_allow}, {63'd0, !d});
    chk({req, " err"}, {48'd0, res_err}, {48'd0, exp_err(d, k, u)});
  endtask

  task automatic wr_rights(logic [31:0] v);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_index = '0; cmd_wdata = v;
    @(negedge clk);
    cmd_valid = 1'b0;
    model = v;
  endtask

  task automatic rd_rights(string req);
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_index = '0;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk({req, " rd_valid"}, {63'd0, rd_valid}, 64'd1);
    chk({req, " rd_data"}, {32'd0, rd_data}, {32'd0, model});
  endtask

  task automatic bad_cmd(logic w, logic [31:0] idx, logic [31:0] v);
    cmd_valid = 1'b1; cmd_write = w; cmd_index = idx; cmd_wdata = v;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R11 bad_op pulse", {63'd0, bad_op}, 64'd1);
    chk("R11 no rd_valid", {63'd0, rd_valid}, 64'd0);
    @(negedge clk);
    chk("R11 bad_op one cycle", {63'd0, bad_op}, 64'd0);
  endtask

  function automatic logic [63:0] ent(int key);
    return {1'b0, 4'(key), 59'h123_4567};
  endfunction

  localparam logic [31:0] EN = 32'h0040_0000;

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 res_valid", {63'd0, res_valid}, 64'd0);
    chk("R1 res_allow", {63'd0, res_allow}, 64'd0);
    chk("R1 res_err", {48'd0, res_err}, 64'd0);
    chk("R1 rd_valid", {63'd0, rd_valid}, 64'd0);
    chk("R1 bad_op", {63'd0, bad_op}, 64'd0);
    rd_rights("R1 rights zero");
    // R12 idle cycle yields no result
    @(negedge clk);
    chk("R12 idle", {63'd0, res_valid}, 64'd0);

    // R4 access-disable on key 7
    wr_rights(32'h1 << 14);
    access("R4 read ad", ent(7), 2'd0, 1'b1, EN);
    access("R4 write ad", ent(7), 2'd1, 1'b1, EN);
    access("R3 other key", ent(6), 2'd1, 1'b1, EN);
    // R5 write-disable only on key 15
    wr_rights(32'h8000_0000);
    access("R5 read wd", ent(15), 2'd0, 1'b1, EN);
    access("R5 write wd", ent(15), 2'd1, 1'b1, EN);
    // R2, R6, R7 overrides with every bit set
    wr_rights(32'hFFFF_FFFF);
    access("R2 disabled", ent(3), 2'd1, 1'b1, 32'hFFBF_FFFF);
    access("R6 fetch", ent(3), 2'd2, 1'b1, EN);
    access("R6 fetch3", ent(0), 2'd3, 1'b1, EN);
    access("R7 supervisor", ent(9), 2'd1, 1'b0, EN);
    access("R8 deny key0", ent(0), 2'd0, 1'b1, EN);
    // R3 low entry bits do not pick the key
    wr_rights(32'h0000_0001);
    access("R3 key from 62:59", 64'h4000_0000_0000_000F, 2'd0, 1'b1, EN);

    // R9 same-cycle write and access uses old rights
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_index = '0; cmd_wdata = 32'h0000_0300;
    access("R9 old rights same cycle", ent(4), 2'd1, 1'b1, EN);
    cmd_valid = 1'b0;
    model = 32'h0000_0300;
    access("R9 new rights next", ent(4), 2'd1, 1'b1, EN);
    rd_rights("R10 read after write");

    // R11 bad index leaves register
    bad_cmd(1'b1, 32'd1, 32'hDEAD_BEEF);
    bad_cmd(1'b0, 32'h8000_0000, 32'h0);
    rd_rights("R11 unchanged");

    // random mix
    for (int i = 0; i < 600; i++) begin
      int sel = int'($urandom_range(0, 9));
      if (sel == 0) begin
        wr_rights($urandom());
      end else if (sel == 1) begin
        rd_rights("R10 random read");
      end else if (sel == 2) begin
        bad_cmd($urandom_range(0, 1) == 1, $urandom_range(1, 32'hFFFF), $urandom());
      end else begin
        logic [31:0] c = $urandom();
        logic [63:0] e = {$urandom(), $urandom()};
        c[22] = ($urandom_range(0, 4) != 0);
        access("R4/R5/R8 random", e, 2'($urandom_range(0, 3)),
               $urandom_range(0, 3) != 0, c);
      end
    end
    rd_rights("R9 final");

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule